// File: doc/BRIEF.md
# Commit-Stage Interrupt Acceptance Controller

This block sits at the retirement end of an out-of-order core and decides the cycle in which an external interrupt is taken. While nothing is held, it watches an incoming request that carries an 8-bit cause with its own valid bit. It accepts the request only when interrupt checking is enabled and the pipeline is not already in a trap or squash. An accepted cause is captured in a holding register, and a fetch-hold flag tells the front end to stop bringing in new instructions.

While the interrupt is held, further requests are ignored. The block waits until the reorder buffer reports empty and no buffered stores remain to be written back. In the clock edge that follows such a cycle it emits, together, a take pulse carrying the held cause, a trap-squash pulse and a clear pulse. The holding register then returns to empty, and sampling may resume.

Top module: `irq_commit_gate`

## Requirements
- R1: After synchronous active-high reset, fetchHold, takePulse, squashPulse and clearPulse are all low and no interrupt is held.
- R2: A request is accepted at a clock edge only if, in the cycle before, irqEnable and irqReq are high and trapPending, trapSquashBusy and extSquashBusy are all low; otherwise it changes no state.
- R3: A request with irqCauseValid low counts as no interrupt and leaves fetchHold low.
- R4: fetchHold rises at the edge that accepts an interrupt and stays high until the edge on which takePulse rises, where it falls.
- R5: While an interrupt is held, new requests are not sampled and the held cause does not change.
- R6: takePulse rises only after a cycle in which an interrupt was held, robEmpty was high and storesOutstanding was low; while either condition fails, the interrupt stays held.
- R7: takePulse, squashPulse and clearPulse are high in exactly the same cycles, and each lasts a single cycle.
- R8: After a take the holding register is empty, so a request presented during the clear-pulse cycle is accepted at the next edge, and no earlier request is accepted.
- R9: While takePulse is high, takeCause equals the 8-bit cause captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqEnable | input | 1 | Interrupt checking enabled |
| irqReq | input | 1 | Interrupt request present |
| irqCauseValid | input | 1 | Cause code is a real interrupt |
| irqCause | input | 8 | Interrupt cause code |
| trapPending | input | 1 | A trap is waiting to be taken |
| trapSquashBusy | input | 1 | A trap squash is in progress |
| extSquashBusy | input | 1 | An external squash is in progress |
| robEmpty | input | 1 | Reorder buffer is empty |
| storesOutstanding | input | 1 | Stores remain to be written back |
| fetchHold | output | 1 | Interrupt held; fetch must stop |
| takePulse | output | 1 | One-cycle pulse: handler starts |
| takeCause | output | 8 | Cause handed to the handler with takePulse |
| squashPulse | output | 1 | One-cycle trap squash event |
| clearPulse | output | 1 | One-cycle interrupt clear indication |

## Verification
The hardest state to reach is an interrupt held for many cycles while requests with fresh causes keep arriving. The bench must show that the held cause survives and the newcomers are dropped. The same applies when a request lands exactly in the clear-pulse cycle. Directed sequences hold storesOutstanding high for several cycles with requests carrying different causes, and they drive a continuous stream of requests with the drain conditions met so that take and re-acceptance alternate. The random phase keeps the drain conditions true less than half the time, so holds of varying length occur often.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned CAUSE_W_DEF = 8;

  typedef struct packed {
    logic latchEn;
    logic takeEn;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        irqEnable,
  input  logic        irqReq,
  input  logic        irqCauseValid,
  input  logic        trapPending,
  input  logic        trapSquashBusy,
  input  logic        extSquashBusy,
  input  logic        robEmpty,
  input  logic        storesOutstanding,
  input  logic        heldValid,
  output ctlStrobes_t strobes
);
  logic sampleOk;
  logic drained;

  always_comb begin
    sampleOk = irqEnable && irqReq && irqCauseValid &&
               !trapPending && !trapSquashBusy && !extSquashBusy;
    drained  = robEmpty && !storesOutstanding;
    // latched path wins over the sampling path
    strobes.takeEn  = heldValid && drained;
    strobes.latchEn = !heldValid && sampleOk;
  end

  // R5
  no_sample_while_held_chk: assert property (@(posedge clk) disable iff (rst)
    heldValid |-> !strobes.latchEn);

  // R6
  take_needs_drain_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.takeEn |-> (robEmpty && !storesOutstanding));
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobes_t        strobes,
  input  logic [CAUSE_W-1:0] irqCause,
  output logic               heldValid,
  output logic               takeStrobe,
  output logic [CAUSE_W-1:0] takeCause
);
  logic [CAUSE_W-1:0] heldCause;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldValid  <= 1'b0;
      heldCause  <= '0;
      takeStrobe <= 1'b0;
      takeCause  <= '0;
    end else begin
      takeStrobe <= strobes.takeEn;
      if (strobes.takeEn) begin
        takeCause <= heldCause;
        heldValid <= 1'b0;
      end else if (strobes.latchEn) begin
        heldCause <= irqCause;
        heldValid <= 1'b1;
      end
    end
  end

  // R5
  held_cause_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (heldValid && $past(heldValid) && !$past(rst)) |-> $stable(heldCause));

  // R7
  take_single_chk: assert property (@(posedge clk) disable iff (rst)
    takeStrobe |=> !takeStrobe);
endmodule

// File: rtl/irq_commit_gate.sv
module irq_commit_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irqEnable,
  input  logic               irqReq,
  input  logic               irqCauseValid,
  input  logic [CAUSE_W-1:0] irqCause,
  input  logic               trapPending,
  input  logic               trapSquashBusy,
  input  logic               extSquashBusy,
  input  logic               robEmpty,
  input  logic               storesOutstanding,
  output logic               fetchHold,
  output logic               takePulse,
  output logic [CAUSE_W-1:0] takeCause,
  output logic               squashPulse,
  output logic               clearPulse
);
  ctlStrobes_t strobes;
  logic        heldValid;
  logic        takeStrobe;

  irq_gate_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .irqEnable(irqEnable), .irqReq(irqReq), .irqCauseValid(irqCauseValid),
    .trapPending(trapPending), .trapSquashBusy(trapSquashBusy),
    .extSquashBusy(extSquashBusy), .robEmpty(robEmpty),
    .storesOutstanding(storesOutstanding),
    .heldValid(heldValid), .strobes(strobes)
  );

  irq_gate_dp #(.CAUSE_W(CAUSE_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .irqCause(irqCause),
    .heldValid(heldValid), .takeStrobe(takeStrobe), .takeCause(takeCause)
  );

  assign fetchHold   = heldValid;
  assign takePulse   = takeStrobe;
  assign squashPulse = takeStrobe;
  assign clearPulse  = takeStrobe;

  // R2
  accept_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(fetchHold) && !$past(rst)) |->
      $past(irqEnable && irqReq && irqCauseValid && !trapPending &&
            !trapSquashBusy && !extSquashBusy));

  // R6
  take_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(takePulse) && !$past(rst)) |->
      $past(fetchHold && robEmpty && !storesOutstanding));

  // R4
  hold_until_take_chk: assert property (@(posedge clk) disable iff (rst)
    (fetchHold && !(robEmpty && !storesOutstanding)) |=> fetchHold);

  // R4
  hold_drops_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    takePulse |-> !fetchHold);

  // R7
  pulses_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (takePulse == squashPulse) && (takePulse == clearPulse));
endmodule

// File: tb/irq_commit_gate_tb.sv
`timescale 1ns/1ps
module irq_commit_gate_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       irqEnable, irqReq, irqCauseValid;
  logic [7:0] irqCause;
  logic       trapPending, trapSquashBusy, extSquashBusy;
  logic       robEmpty, storesOutstanding;
  logic       fetchHold, takePulse, squashPulse, clearPulse;
  logic [7:0] takeCause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the requirement-level state
  bit       mHeld;
  bit [7:0] mCause;
  bit       eTake;
  bit [7:0] eCause;

  always #2.5 clk = ~clk;

  irq_commit_gate u_dut (
    .clk(clk), .rst(rst),
    .irqEnable(irqEnable), .irqReq(irqReq), .irqCauseValid(irqCauseValid),
    .irqCause(irqCause), .trapPending(trapPending),
    .trapSquashBusy(trapSquashBusy), .extSquashBusy(extSquashBusy),
    .robEmpty(robEmpty), .storesOutstanding(storesOutstanding),
    .fetchHold(fetchHold), .takePulse(takePulse), .takeCause(takeCause),
    .squashPulse(squashPulse), .clearPulse(clearPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit acceptNow();
    return !mHeld && irqEnable && irqReq && irqCauseValid &&
           !trapPending && !trapSquashBusy && !extSquashBusy;
  endfunction

  function automatic bit takeNow();
    return mHeld && robEmpty && !storesOutstanding;
  endfunction

  // one clock: inputs already driven; predict, step, compare
  task automatic step();
    bit lat, tk;
    lat = acceptNow();
    tk  = takeNow();
    eTake = tk;
    if (tk) begin
      eCause = mCause;
      mHeld  = 0;
    end else if (lat) begin
      mCause = irqCause;
      mHeld  = 1;
    end
    @(posedge clk);
    #2;
    chk("R4 fetchHold", int'(fetchHold), int'(mHeld));
    chk("R6 takePulse", int'(takePulse), int'(eTake));
    chk("R7 squashPulse", int'(squashPulse), int'(eTake));
    chk("R7 clearPulse", int'(clearPulse), int'(eTake));
    if (eTake) chk("R9 takeCause", int'(takeCause), int'(eCause));
    @(negedge clk);
  endtask

  task automatic quiet();
    irqEnable = 1; irqReq = 0; irqCauseValid = 0; irqCause = 0;
    trapPending = 0; trapSquashBusy = 0; extSquashBusy = 0;
    robEmpty = 1; storesOutstanding = 0;
  endtask

  task automatic drain();
    quiet();
    repeat (3) step();
  endtask

  task automatic request(input bit [7:0] c);
    irqReq = 1; irqCauseValid = 1; irqCause = c;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    quiet();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mHeld = 0; mCause = 0; eTake = 0; eCause = 0;
    // R1 reset state
    chk("R1 fetchHold", int'(fetchHold), 0);
    chk("R1 takePulse", int'(takePulse), 0);
    chk("R1 squashPulse", int'(squashPulse), 0);
    chk("R1 clearPulse", int'(clearPulse), 0);

    // R2 each blocking condition ignores a valid request
    drain();
    request(8'h11); extSquashBusy = 1; step();
    chk("R2 ext squash ignored", int'(fetchHold), 0);
    quiet(); request(8'h12); trapSquashBusy = 1; step();
    chk("R2 trap squash ignored", int'(fetchHold), 0);
    quiet(); request(8'h13); trapPending = 1; step();
    chk("R2 trap pending ignored", int'(fetchHold), 0);
    quiet(); request(8'h14); irqEnable = 0; step();
    chk("R2 disabled ignored", int'(fetchHold), 0);

    // R3 invalid cause is no interrupt
    quiet(); request(8'h15); irqCauseValid = 0; step();
    chk("R3 invalid cause", int'(fetchHold), 0);

    // R5/R6 stores outstanding delays take; newer causes dropped
    quiet(); storesOutstanding = 1; request(8'hA5); step();
    chk("R4 latched", int'(fetchHold), 1);
    for (int i = 0; i < 5; i++) begin
      request(8'h40 + 8'(i));
      step();
      chk("R6 no take with stores", int'(takePulse), 0);
    end
    robEmpty = 0; storesOutstanding = 0; step();
    chk("R6 no take with rob busy", int'(takePulse), 0);
    irqReq = 0; robEmpty = 1; step();
    chk("R9 held cause survives", int'(takeCause), 8'hA5);
    chk("R5 take seen", int'(takePulse), 1);

    // R8 back-to-back requests
    drain();
    request(8'h21); step();
    chk("R8 first latched", int'(fetchHold), 1);
    request(8'h22); step();
    chk("R8 take of first", int'(takePulse), 1);
    chk("R8 second not yet", int'(fetchHold), 0);
    chk("R9 first cause", int'(takeCause), 8'h21);
    request(8'h23); step();
    chk("R8 accepted after clear", int'(fetchHold), 1);
    irqReq = 0; step();
    chk("R9 second cause", int'(takeCause), 8'h23);

    // random phase
    drain();
    for (int n = 0; n < 4000; n++) begin
      irqEnable         = ($urandom % 10) < 8;
      irqReq            = ($urandom % 10) < 3;
      irqCauseValid     = ($urandom % 10) < 8;
      irqCause          = 8'($urandom);
      trapPending       = ($urandom % 100) < 15;
      trapSquashBusy    = ($urandom % 100) < 15;
      extSquashBusy     = ($urandom % 100) < 15;
      robEmpty          = ($urandom % 10) < 4;
      storesOutstanding = ($urandom % 10) < 4;
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule